// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block sequences the transfers between a fast working SRAM and the nonvolatile backup copy behind it. It watches a power-good comparator flag, decoded command strobes (save, restore, autosave off, autosave on), the SRAM write strobe and the level of a shared open-drain request/busy pin. From these it decides when to copy the SRAM into the backup image (a store) and when to rebuild the SRAM from that image (a restore). A restore runs in two phases: a timed clear phase, then a load phase.

Transfers to the backup array use a one-cycle start pulse with a direction bit, and they end on a done pulse from the array. While any operation runs, the block closes SRAM access and drops its ready status. It pulls the shared pin low during every store and during the power-up restore. A dirty flag records whether any write has been accepted since the last completed store or restore. Stores requested by power loss or by the pin run only when that flag is set. A software store always runs. Clear-phase length and pin-request delay are parameters in clock cycles.

Top module: `nvs_seq`

## Requirements
- R1: While reset is asserted, and after it is released, the block is powered off: `ready_o`, `mem_en_o`, `pin_pull_o`, `bk_start_o`, `bk_op_o` and `sram_clr_o` are 0, and the autosave bit `bk_auto_o` is 1.
- R2: When `pwr_ok_i` is 1 in the off state, `sram_clr_o` goes high on the next cycle for exactly CLR_CYC cycles. The following cycle carries a one-cycle `bk_start_o` with `bk_op_o`=1 (load). `pin_pull_o` stays high through both phases, and `ready_o` rises the cycle after `bk_done_i`.
- R3: While `sram_clr_o` is high, no backup transfer is started. The backup image is written only by a transfer started with `bk_op_o`=0.
- R4: `cmd_save_i` while `mem_en_o` is 1 gives, on the next cycle, a one-cycle `bk_start_o` with `bk_op_o`=0, whether or not the dirty flag is set. `bk_start_o` is never high two cycles in a row.
- R5: From the store start until the cycle after `bk_done_i`, `pin_pull_o` is 1 and `ready_o` and `mem_en_o` are 0.
- R6: `pin_in_i` low in the ready state starts a wait of DLY_CYC cycles. A store follows only if the dirty flag is set. Otherwise no transfer starts.
- R7: `mem_en_o` is 0 in every cycle where `pin_in_i` is 0. After a pin-requested or software store, or after a pin wait with no store, `ready_o` returns only the cycle after `pin_in_i` is seen high.
- R8: `mem_en_o` is 0 in the same cycle that `pwr_ok_i` is 0. On power loss in the ready or pin-wait states, a store starts if autosave is enabled and the dirty flag is set; otherwise the block goes off. A store that finishes with power low goes off.
- R9: `cmd_restore_i` while `mem_en_o` is 1 runs the clear phase and then the load phase, with `pin_pull_o` kept at 0.
- R10: `cmd_auto_off_i` or `cmd_auto_on_i` while `mem_en_o` is 1 clears or sets the autosave bit on the next cycle, with off winning if both are high. On load completion the bit takes `bk_auto_i`.
- R11: The dirty flag is set only by `mem_wr_i` in a cycle with `mem_en_o`=1. It is cleared when a store or load completes.
- R12: Save, restore and autosave commands are ignored in any cycle where `mem_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | 1 while supply is above the switch threshold |
| cmd_save_i | input | 1 | Software store command strobe |
| cmd_restore_i | input | 1 | Software restore command strobe |
| cmd_auto_off_i | input | 1 | Disable autosave strobe |
| cmd_auto_on_i | input | 1 | Enable autosave strobe |
| mem_wr_i | input | 1 | SRAM write strobe |
| pin_in_i | input | 1 | Sampled level of the shared open-drain pin |
| bk_done_i | input | 1 | Backup array transfer complete pulse |
| bk_auto_i | input | 1 | Autosave bit read back from the backup image |
| ready_o | output | 1 | Status ready bit (0 = busy) |
| mem_en_o | output | 1 | SRAM access allowed |
| pin_pull_o | output | 1 | Drive the shared pin low |
| bk_start_o | output | 1 | One-cycle transfer start |
| bk_op_o | output | 1 | Transfer direction: 1 load into SRAM, 0 store to backup |
| sram_clr_o | output | 1 | SRAM clear phase active |
| bk_auto_o | output | 1 | Autosave bit, saved with each store |

## Verification
The assertions assume the pin level and power flag arrive already synchronous to the clock. They also assume `bk_done_i` pulses only while a transfer is outstanding, since a stray done in another state is not guarded against. The stimulus changes every input one time unit after a rising edge. It raises `bk_done_i` only in a cycle where the block is in a load or store, and it holds the pin low only for whole cycles. The bench treats power loss as a level held until the off state is reached.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_CLR      = 3'd1,
    ST_LOAD     = 3'd2,
    ST_IDLE     = 3'd3,
    ST_PIN_WAIT = 3'd4,
    ST_SAVE     = 3'd5,
    ST_PIN_HOLD = 3'd6
  } nvs_state_e;
endpackage

// File: rtl/nvs_rst_sync.sv
module nvs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/nvs_step_timer.sv
module nvs_step_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // counts up from zero after each state change, saturating at all ones
  always_comb begin
    cnt_en = restart_i || (cnt_q != '1);
    cnt_d  = restart_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/nvs_flags.sv
module nvs_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_ok_i,
  input  logic mem_wr_i,
  input  logic cmd_auto_off_i,
  input  logic cmd_auto_on_i,
  input  logic save_done_i,
  input  logic load_done_i,
  input  logic bk_auto_i,
  output logic dirty_o,
  output logic auto_en_o
);
  logic dirty_q, dirty_d, dirty_en;
  logic auto_q, auto_d, auto_en;

  always_comb begin
    dirty_en = save_done_i || load_done_i || (acc_ok_i && mem_wr_i);
    dirty_d  = !(save_done_i || load_done_i);
  end

  always_comb begin
    auto_en = load_done_i || (acc_ok_i && (cmd_auto_off_i || cmd_auto_on_i));
    if (load_done_i)         auto_d = bk_auto_i;
    else if (cmd_auto_off_i) auto_d = 1'b0;
    else                     auto_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q <= 1'b0;
      auto_q  <= 1'b1;
    end else begin
      if (dirty_en) dirty_q <= dirty_d;
      if (auto_en)  auto_q  <= auto_d;
    end
  end

  assign dirty_o   = dirty_q;
  assign auto_en_o = auto_q;
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl import nvs_pkg::*; #(
  parameter int CLR_CYC = 16,
  parameter int DLY_CYC = 32,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_ok_i,
  input  logic             pin_in_i,
  input  logic             cmd_save_i,
  input  logic             cmd_restore_i,
  input  logic             bk_done_i,
  input  logic             dirty_i,
  input  logic             auto_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  output nvs_state_e       state_o,
  output logic             restart_o,
  output logic             start_o,
  output logic             pu_o
);
  localparam logic [CNT_W-1:0] CLR_LAST = CNT_W'(CLR_CYC - 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DLY_CYC - 1);

  nvs_state_e state_q, state_d, pwr_exit;
  logic       start_q, start_d;
  logic       pu_q, pu_d;

  always_comb begin
    pwr_exit = (auto_en_i && dirty_i) ? ST_SAVE : ST_OFF;
    state_d  = state_q;
    case (state_q)
      ST_OFF:      if (pwr_ok_i) state_d = ST_CLR;
      ST_CLR:      if (cnt_i == CLR_LAST) state_d = ST_LOAD;
      ST_LOAD:     if (bk_done_i) state_d = ST_IDLE;
      ST_IDLE: begin
        if (!pwr_ok_i)          state_d = pwr_exit;
        else if (!pin_in_i)     state_d = ST_PIN_WAIT;
        else if (cmd_save_i)    state_d = ST_SAVE;
        else if (cmd_restore_i) state_d = ST_CLR;
      end
      ST_PIN_WAIT: begin
        if (!pwr_ok_i)               state_d = pwr_exit;
        else if (cnt_i == DLY_LAST)  state_d = dirty_i ? ST_SAVE : ST_PIN_HOLD;
      end
      ST_SAVE:     if (bk_done_i) state_d = pwr_ok_i ? ST_PIN_HOLD : ST_OFF;
      ST_PIN_HOLD: begin
        if (!pwr_ok_i)     state_d = pwr_exit;
        else if (pin_in_i) state_d = ST_IDLE;
      end
      default:     state_d = ST_OFF;
    endcase
  end

  always_comb begin
    restart_o = (state_d != state_q);
    start_d   = restart_o && ((state_d == ST_LOAD) || (state_d == ST_SAVE));
    if (state_q == ST_OFF && state_d == ST_CLR)       pu_d = 1'b1;
    else if (state_q == ST_IDLE && state_d == ST_CLR) pu_d = 1'b0;
    else                                              pu_d = pu_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      start_q <= 1'b0;
      pu_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      pu_q    <= pu_d;
    end
  end

  assign state_o = state_q;
  assign start_o = start_q;
  assign pu_o    = pu_q;
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq import nvs_pkg::*; #(
  parameter int CLR_CYC = 16,
  parameter int DLY_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok_i,
  input  logic cmd_save_i,
  input  logic cmd_restore_i,
  input  logic cmd_auto_off_i,
  input  logic cmd_auto_on_i,
  input  logic mem_wr_i,
  input  logic pin_in_i,
  input  logic bk_done_i,
  input  logic bk_auto_i,
  output logic ready_o,
  output logic mem_en_o,
  output logic pin_pull_o,
  output logic bk_start_o,
  output logic bk_op_o,
  output logic sram_clr_o,
  output logic bk_auto_o
);
  localparam int MAX_CYC = (CLR_CYC > DLY_CYC) ? CLR_CYC : DLY_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             rst_s_n;
  logic             restart, start, pu;
  logic             dirty, auto_en;
  logic             save_done, load_done;
  logic [CNT_W-1:0] cnt;
  nvs_state_e       state;

  nvs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  nvs_step_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_s_n), .restart_i(restart), .cnt_o(cnt)
  );

  nvs_ctrl #(.CLR_CYC(CLR_CYC), .DLY_CYC(DLY_CYC), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .pwr_ok_i(pwr_ok_i), .pin_in_i(pin_in_i),
    .cmd_save_i(cmd_save_i), .cmd_restore_i(cmd_restore_i),
    .bk_done_i(bk_done_i), .dirty_i(dirty), .auto_en_i(auto_en),
    .cnt_i(cnt), .state_o(state), .restart_o(restart), .start_o(start),
    .pu_o(pu)
  );

  always_comb begin
    save_done = (state == ST_SAVE) && bk_done_i;
    load_done = (state == ST_LOAD) && bk_done_i;
  end

  nvs_flags u_flags (
    .clk(clk), .rst_n(rst_s_n), .acc_ok_i(mem_en_o), .mem_wr_i(mem_wr_i),
    .cmd_auto_off_i(cmd_auto_off_i), .cmd_auto_on_i(cmd_auto_on_i),
    .save_done_i(save_done), .load_done_i(load_done), .bk_auto_i(bk_auto_i),
    .dirty_o(dirty), .auto_en_o(auto_en)
  );

  always_comb begin
    ready_o    = (state == ST_IDLE);
    mem_en_o   = ready_o && pwr_ok_i && pin_in_i;
    pin_pull_o = (state == ST_SAVE) ||
                 (((state == ST_CLR) || (state == ST_LOAD)) && pu);
    bk_start_o = start;
    bk_op_o    = (state == ST_LOAD);
    sram_clr_o = (state == ST_CLR);
    bk_auto_o  = auto_en;
  end
endmodule

// File: rtl/nvs_chk.sv
module nvs_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_ok_i,
  input logic pin_in_i,
  input logic cmd_save_i,
  input logic cmd_auto_off_i,
  input logic ready_o,
  input logic mem_en_o,
  input logic pin_pull_o,
  input logic bk_start_o,
  input logic bk_op_o,
  input logic sram_clr_o,
  input logic bk_auto_o
);
  // R2: a finished clear phase is followed at once by a load start
  p_load_after_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_clr_o) |-> (bk_start_o && bk_op_o));

  // R3: no transfer starts during the clear phase
  p_clear_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sram_clr_o |-> !bk_start_o);

  // R4: start is a single-cycle pulse
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bk_start_o |=> !bk_start_o);

  // R4: an accepted save command starts a store on the next cycle
  p_save_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && cmd_save_i) |=> (bk_start_o && !bk_op_o));

  // R5: a store holds the pin low and closes access
  p_store_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_start_o && !bk_op_o) |-> (pin_pull_o && !ready_o && !mem_en_o));

  // R7: a low pin closes access
  p_pin_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_in_i |-> !mem_en_o);

  // R8: low power closes access in the same cycle
  p_pwr_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok_i |-> !mem_en_o);

  // R10: an accepted disable command clears the autosave bit
  p_auto_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && cmd_auto_off_i) |=> !bk_auto_o);
endmodule

bind nvs_seq nvs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_ok_i), .pin_in_i(pin_in_i),
  .cmd_save_i(cmd_save_i), .cmd_auto_off_i(cmd_auto_off_i),
  .ready_o(ready_o), .mem_en_o(mem_en_o), .pin_pull_o(pin_pull_o),
  .bk_start_o(bk_start_o), .bk_op_o(bk_op_o), .sram_clr_o(sram_clr_o),
  .bk_auto_o(bk_auto_o)
);

// File: tb/sim_nvs_seq.sv
`timescale 1ns/1ps
module sim_nvs_seq;
  localparam int CLR_CYC = 3;
  localparam int DLY_CYC = 4;
  localparam int NVEC    = 35;

  logic clk = 1'b0;
  logic rst_n;
  logic pwr, pin, sv, rs, aoff, aon, wr, done, bauto;
  logic ready_o, mem_en_o, pin_pull_o, bk_start_o, bk_op_o, sram_clr_o, bk_auto_o;
  int   nchk = 0;
  int   nfail = 0;
  bit   fin = 1'b0;

  always #2 clk = ~clk;

  nvs_seq #(.CLR_CYC(CLR_CYC), .DLY_CYC(DLY_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr), .cmd_save_i(sv),
    .cmd_restore_i(rs), .cmd_auto_off_i(aoff), .cmd_auto_on_i(aon),
    .mem_wr_i(wr), .pin_in_i(pin), .bk_done_i(done), .bk_auto_i(bauto),
    .ready_o(ready_o), .mem_en_o(mem_en_o), .pin_pull_o(pin_pull_o),
    .bk_start_o(bk_start_o), .bk_op_o(bk_op_o), .sram_clr_o(sram_clr_o),
    .bk_auto_o(bk_auto_o)
  );

  // inputs  [15:7] = pwr pin save restore aoff aon wr done bauto
  // expect  [6:0]  = ready en pull start op clr auto
  localparam logic [15:0] VEC [NVEC] = '{
    {9'b110000000, 7'b0010011}, // 0  power up, clear   R2
    {9'b110000000, 7'b0010011}, // 1
    {9'b110000000, 7'b0010011}, // 2  R3
    {9'b110000000, 7'b0011101}, // 3  load start
    {9'b110000000, 7'b0010101}, // 4
    {9'b110000011, 7'b1100001}, // 5  load done -> ready
    {9'b111000000, 7'b0011001}, // 6  save while clean   R4
    {9'b110000010, 7'b0000001}, // 7  store done -> hold  R5
    {9'b110000000, 7'b1100001}, // 8
    {9'b100000000, 7'b0000001}, // 9  pin low -> wait     R6
    {9'b100000000, 7'b0000001}, // 10
    {9'b100000000, 7'b0000001}, // 11
    {9'b100000000, 7'b0000001}, // 12
    {9'b100000000, 7'b0000001}, // 13 clean: no store     R7
    {9'b110000000, 7'b1100001}, // 14
    {9'b110000100, 7'b1100001}, // 15 write -> dirty      R11
    {9'b100000000, 7'b0000001}, // 16
    {9'b100000000, 7'b0000001}, // 17
    {9'b100000000, 7'b0000001}, // 18
    {9'b100000000, 7'b0000001}, // 19
    {9'b100000000, 7'b0011001}, // 20 dirty: store
    {9'b100000010, 7'b0000001}, // 21
    {9'b100000000, 7'b0000001}, // 22 pin still low
    {9'b110000000, 7'b1100001}, // 23
    {9'b110010000, 7'b1100000}, // 24 autosave off        R10
    {9'b110000100, 7'b1100000}, // 25
    {9'b010000000, 7'b0000000}, // 26 power loss, no save R8
    {9'b110000000, 7'b0010010}, // 27
    {9'b110000000, 7'b0010010}, // 28
    {9'b110000000, 7'b0010010}, // 29
    {9'b110000000, 7'b0011100}, // 30
    {9'b110000011, 7'b1100001}, // 31 bit from backup
    {9'b110000100, 7'b1100001}, // 32
    {9'b010000000, 7'b0011001}, // 33 power loss, save
    {9'b010000010, 7'b0000001}  // 34 -> off
  };

  function automatic string vec_req(int i);
    if (i <= 5)       return "R2 R3";
    else if (i <= 8)  return "R4 R5";
    else if (i <= 14) return "R6 R7";
    else if (i <= 23) return "R6 R11";
    else if (i <= 26) return "R10 R8";
    else if (i <= 31) return "R2 R10";
    else              return "R8";
  endfunction

  function automatic logic [6:0] outs();
    return {ready_o, mem_en_o, pin_pull_o, bk_start_o, bk_op_o, sram_clr_o, bk_auto_o};
  endfunction

  task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic go();
    @(posedge clk);
    #1;
  endtask

  task automatic apply(input logic [8:0] v);
    {pwr, pin, sv, rs, aoff, aon, wr, done, bauto} = v;
  endtask

  task automatic power_up(input logic ba);
    apply(9'b110000000);
    repeat (1 + CLR_CYC) go();
    done = 1'b1; bauto = ba;
    go();
    done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      nfail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    apply(9'b010000000);
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", outs(), 7'b0000001);
    rst_n = 1'b1;
    repeat (3) go();
    check("R1 after release", outs(), 7'b0000001);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][15:7]);
      go();
      check(vec_req(i), outs(), VEC[i][6:0]);
    end

    // R9: software restore, pin left released; load brings bit 0 (R10)
    power_up(1'b1);
    check("R2 ready", {6'd0, ready_o}, 7'd1);
    rs = 1'b1; go(); rs = 1'b0;
    check("R9 clear no pull", {5'd0, sram_clr_o, pin_pull_o}, 7'b0000010);
    repeat (CLR_CYC) go();
    check("R9 load start", {4'd0, bk_start_o, bk_op_o, pin_pull_o}, 7'b0000110);
    done = 1'b1; bauto = 1'b0; go(); done = 1'b0;
    check("R10 bit from load", {5'd0, ready_o, bk_auto_o}, 7'b0000010);
    aon = 1'b1; go(); aon = 1'b0;
    check("R10 enable", {6'd0, bk_auto_o}, 7'd1);

    // R11: write while pin low is not accepted; pin wait ends with no store
    pin = 1'b0; wr = 1'b1; go(); wr = 1'b0;
    repeat (DLY_CYC) go();
    check("R11 R6 no store", {4'd0, ready_o, bk_start_o, pin_pull_o}, 7'd0);
    pin = 1'b1; go();
    check("R7 back to ready", {5'd0, ready_o, mem_en_o}, 7'b0000011);

    // R12: commands during a store are ignored
    sv = 1'b1; go(); sv = 1'b0;
    check("R4 store start", {5'd0, bk_start_o, bk_op_o}, 7'b0000010);
    rs = 1'b1; aoff = 1'b1; sv = 1'b1; go();
    rs = 1'b0; aoff = 1'b0; sv = 1'b0;
    check("R12 busy ignore", {3'd0, bk_start_o, sram_clr_o, bk_auto_o, pin_pull_o}, 7'b0000011);
    done = 1'b1; go(); done = 1'b0;
    go();
    check("R12 after store", {4'd0, ready_o, sram_clr_o, bk_auto_o}, 7'b0000101);

    // R1: reset mid-run restores the autosave bit and the off state
    aoff = 1'b1; go(); aoff = 1'b0;
    check("R10 disable", {6'd0, bk_auto_o}, 7'd0);
    rst_n = 1'b0; #1;
    check("R1 mid-run reset", outs(), 7'b0000001);

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule